// File: doc/BRIEF.md
# Timer / Event Counter with Pulse-Width Capture

This block is an 8-bit counting peripheral with three modes, set through a control register. In timer mode it counts strobes from a power-of-two prescaler that runs on an internal base clock. In event mode it counts edges seen on an external pin. In capture mode it measures how long one external pulse lasts, using the prescaled base clock. A small register port gives software access to the control register, the counter and a reload value. An interrupt output and a wake-up output report counter overflow.

The external pin is not related to the block clock. It passes through a synchronizer, and edges are found by comparing successive synchronized samples. The prescaler does not make a derived clock. It produces a single-cycle enable strobe, so the whole block stays in one clock domain. Two base sources are available: the system clock, with an optional fixed divide by four chosen by a parameter, and a slow oscillator that arrives as a strobe input.

In capture mode, setting the enable bit only arms the counter. Counting begins at the selected active edge of the pin. It ends when the pin returns to its idle level, and at that point the hardware clears the enable bit by itself. In the other modes, only a register write can clear the enable bit.

Top module: `evt_timer`

## Requirements
- R1: After reset the control register, counter, reload value, `irq_o` and `wake_o` are all zero. Address 0 is the control register and reads back what was written. Its fields are: bits 7:6 mode, bit 5 base source, bit 4 enable, bit 3 edge select, bits 2:0 prescale rate. Writing address 1 sets the reload value, and also loads the counter when the enable bit is low. Reading address 1 returns the counter.
- R2: In timer mode (mode 2'b10) with enable set, the counter steps by one on each prescaler strobe. Rate N gives one strobe every 2^N base ticks. Any control write restarts the prescaler phase, so the first step lands on the 2^N-th clock edge after the write edge.
- R3: A step taken from all-ones reloads the counter from the reload value, and `irq_o` is high for the one cycle that follows.
- R4: With the base-source bit at 0 the base tick is every clock cycle, or every fourth cycle when `SYS_DIV4` = 1. With the bit at 1, each high cycle of `slow_tick` is one base tick.
- R5: In event mode (mode 2'b01) with enable set, the counter steps once per synchronized pin edge: rising edges when the edge-select bit is 1, falling edges when it is 0. A pin change driven before clock edge E0 is counted at edge E2. The prescale rate has no effect in this mode.
- R6: While `sleep_i` is high, timer-mode and capture-mode counting is held and event-mode counting goes on. An overflow taken while `sleep_i` is high raises `wake_o` in the same cycle as `irq_o`.
- R7: A control write in capture mode (mode 2'b11) that moves the enable bit from 0 to 1 clears the counter to zero. The counter then stays at zero until the active edge arrives.
- R8: With edge select 0, capture starts on a falling pin edge and stops on the next rising edge. With edge select 1, it starts on a rising edge and stops on the next falling edge. At rate 0 with the system base, the result equals the pulse width in clock cycles.
- R9: When capture stops, the enable bit clears by itself. From then on the counter holds its value through further pin activity and through reads.
- R10: In timer and event modes the enable bit stays set through overflows and changes only by register write. Mode 2'b00 does not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (system clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 counter/reload |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for the selected register |
| tmr_pin | input | 1 | External timer pin, asynchronous |
| slow_tick | input | 1 | One-cycle strobes from the slow oscillator |
| sleep_i | input | 1 | System is in idle/sleep |
| irq_o | output | 1 | Overflow interrupt pulse |
| wake_o | output | 1 | Wake-up request on overflow during sleep |

## Verification
The bench builds two copies of the block on shared stimulus. The main copy keeps the defaults (`CNT_W` = 8, `SYNC_STAGES` = 2, `SYS_DIV4` = 0). A second copy sets `SYS_DIV4` = 1 and is compared on a timer run. The 8-bit width lets short preloads near all-ones reach overflow and reload within a few cycles. The two-stage synchronizer fixes the event latency at a known edge, and both base-clock variants are covered.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int CTRL_W = 8;
    localparam int RATE_W = 3;

    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_COUNT = 1'b1;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_EVENT   = 2'b01,
        MODE_TIMER   = 2'b10,
        MODE_CAPTURE = 2'b11
    } tmr_mode_e;

    // Packed MSB first: mode[7:6] src_slow[5] run[4] edge_hi[3] rate[2:0]
    typedef struct packed {
        tmr_mode_e         mode;
        logic              src_slow;
        logic              run;
        logic              edge_hi;
        logic [RATE_W-1:0] rate;
    } ctrl_reg_t;

endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic level,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], pin_async};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level = s_q.chain[STAGES-1];
    assign rise  = level & ~s_q.prev;
    assign fall  = ~level & s_q.prev;

endmodule

// File: rtl/evt_timer_presc.sv
module evt_timer_presc #(
    parameter int RATE_W   = 3,
    parameter bit SYS_DIV4 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              src_slow,
    input  logic              slow_tick,
    input  logic [RATE_W-1:0] rate,
    output logic              strobe
);

    localparam int PRE_W = (1 << RATE_W) - 1;

    logic             sys_tick;
    logic             base_tick;
    logic [PRE_W-1:0] mask;
    logic [PRE_W-1:0] pre_d, pre_q;

    generate
        if (SYS_DIV4) begin : g_div4
            logic [1:0] div_d, div_q;
            always_comb begin
                div_d = restart ? 2'd0 : div_q + 2'd1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end
            assign sys_tick = (div_q == 2'd3);
        end else begin : g_div1
            assign sys_tick = 1'b1;
        end
    endgenerate

    always_comb begin
        base_tick = src_slow ? slow_tick : sys_tick;
        mask      = ~({PRE_W{1'b1}} << rate);
        strobe    = base_tick && ((pre_q & mask) == mask);
        if (restart)        pre_d = '0;
        else if (base_tick) pre_d = pre_q + PRE_W'(1);
        else                pre_d = pre_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             strobe,
    input  logic             pin_rise,
    input  logic             pin_fall,
    input  logic             sleep,
    output ctrl_reg_t        ctrl,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             wake
);

    typedef struct packed {
        ctrl_reg_t        ctrl;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] preload;
        logic             meas;
        logic             irq;
        logic             wake;
    } core_state_t;

    core_state_t s_d, s_q;
    ctrl_reg_t   wr_ctrl;
    logic        start_edge;
    logic        stop_edge;
    logic        step;

    always_comb begin
        s_d      = s_q;
        s_d.irq  = 1'b0;
        s_d.wake = 1'b0;
        wr_ctrl  = ctrl_reg_t'(wr_data[CTRL_W-1:0]);

        start_edge = s_q.ctrl.edge_hi ? pin_rise : pin_fall;
        stop_edge  = s_q.ctrl.edge_hi ? pin_fall : pin_rise;

        unique case (s_q.ctrl.mode)
            MODE_EVENT:   step = s_q.ctrl.run && start_edge;
            MODE_TIMER:   step = s_q.ctrl.run && strobe && !sleep;
            MODE_CAPTURE: step = s_q.meas && strobe && !sleep;
            default:      step = 1'b0;
        endcase

        if (step) begin
            if (s_q.count == {CNT_W{1'b1}}) begin
                s_d.count = s_q.preload;
                s_d.irq   = 1'b1;
                s_d.wake  = sleep;
            end else begin
                s_d.count = s_q.count + CNT_W'(1);
            end
        end

        if (s_q.ctrl.mode == MODE_CAPTURE && s_q.ctrl.run) begin
            if (!s_q.meas && start_edge) begin
                s_d.meas = 1'b1;
            end else if (s_q.meas && stop_edge) begin
                s_d.meas     = 1'b0;
                s_d.ctrl.run = 1'b0;
            end
        end

        if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                s_d.ctrl = wr_ctrl;
                if (!(wr_ctrl.run && wr_ctrl.mode == MODE_CAPTURE)) begin
                    s_d.meas = 1'b0;
                end
                if (wr_ctrl.run && !s_q.ctrl.run && wr_ctrl.mode == MODE_CAPTURE) begin
                    s_d.count = '0;
                end
            end else begin
                s_d.preload = wr_data;
                if (!s_q.ctrl.run) s_d.count = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl  = s_q.ctrl;
    assign count = s_q.count;
    assign irq   = s_q.irq;
    assign wake  = s_q.wake;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit SYS_DIV4    = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             tmr_pin,
    input  logic             slow_tick,
    input  logic             sleep_i,
    output logic             irq_o,
    output logic             wake_o
);

    ctrl_reg_t        ctrl_q;
    logic [CNT_W-1:0] count_q;
    logic             pin_level;
    logic             pin_rise;
    logic             pin_fall;
    logic             psc_strobe;
    logic             ctrl_write;

    assign ctrl_write = reg_we && (reg_addr == ADDR_CTRL);

    evt_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (tmr_pin),
        .level     (pin_level),
        .rise      (pin_rise),
        .fall      (pin_fall)
    );

    evt_timer_presc #(.RATE_W(RATE_W), .SYS_DIV4(SYS_DIV4)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (ctrl_write),
        .src_slow  (ctrl_q.src_slow),
        .slow_tick (slow_tick),
        .rate      (ctrl_q.rate),
        .strobe    (psc_strobe)
    );

    evt_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .strobe   (psc_strobe),
        .pin_rise (pin_rise),
        .pin_fall (pin_fall),
        .sleep    (sleep_i),
        .ctrl     (ctrl_q),
        .count    (count_q),
        .irq      (irq_o),
        .wake     (wake_o)
    );

    assign reg_rdata = (reg_addr == ADDR_CTRL) ? CNT_W'(ctrl_q) : count_q;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input tmr_mode_e        mode,
    input logic             run,
    input logic             edge_hi,
    input logic [CNT_W-1:0] count,
    input logic             pin_level,
    input logic             sleep_i,
    input logic             irq_o,
    input logic             wake_o
);

    AST_WAKE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> irq_o); // R6

    AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(sleep_i)); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> (count == $past(count) || count == $past(count) + CNT_W'(1) || irq_o)); // R2

    AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode != MODE_CAPTURE && !reg_we) |=> run); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_we) |=> $stable(count)); // R9

    AST_CAP_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_CAPTURE && !reg_we) |=>
            (run || ($past(pin_level) != $past(edge_hi)))); // R8

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .mode      (ctrl_q.mode),
    .run       (ctrl_q.run),
    .edge_hi   (ctrl_q.edge_hi),
    .count     (count_q),
    .pin_level (pin_level),
    .sleep_i   (sleep_i),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
);

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] rdata_div4;
    logic       tmr_pin = 1'b0;
    logic       slow_tick = 1'b0;
    logic       sleep_i = 1'b0;
    logic       irq_o, wake_o;
    logic       irq_d4, wake_d4;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    evt_timer #(.CNT_W(8), .SYNC_STAGES(2), .SYS_DIV4(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_pin(tmr_pin),
        .slow_tick(slow_tick), .sleep_i(sleep_i), .irq_o(irq_o), .wake_o(wake_o)
    );

    evt_timer #(.CNT_W(8), .SYNC_STAGES(2), .SYS_DIV4(1'b1)) u_dut_div4 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_div4), .tmr_pin(tmr_pin),
        .slow_tick(slow_tick), .sleep_i(sleep_i), .irq_o(irq_d4), .wake_o(wake_d4)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge: write edge is the next posedge, returns at the negedge after it.
    task automatic wr(input logic a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); check("R1 reset ctrl", v, 8'h00);
        rd(1'b1, v); check("R1 reset count", v, 8'h00);
        check("R1 reset irq", irq_o, 1'b0);
        check("R1 reset wake", wake_o, 1'b0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(1'b1, 8'h5A);
        rd(1'b1, v); check("R1 count load while stopped", v, 8'h5A);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); check("R1 ctrl readback", v, 8'h0B);
        wr(1'b0, 8'h10);
        cyc(5);
        rd(1'b1, v); check("R10 mode off does not count", v, 8'h5A);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_timer();
        logic [7:0] v;
        wr(1'b1, 8'h10);
        wr(1'b0, 8'h90);
        cyc(6);
        rd(1'b1, v); check("R2 timer rate0", v, 8'h16);
        check("R4 system clock div4 variant", rdata_div4, 8'h11);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h92);
        cyc(9);
        rd(1'b1, v); check("R2 timer rate2 first", v, 8'h02);
        cyc(4);
        rd(1'b1, v); check("R2 timer rate2 second", v, 8'h03);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        wr(1'b1, 8'hFD);
        wr(1'b0, 8'h90);
        cyc(2);
        rd(1'b1, v); check("R3 before wrap", v, 8'hFF);
        check("R3 no irq before wrap", irq_o, 1'b0);
        cyc(1);
        rd(1'b1, v); check("R3 reload on wrap", v, 8'hFD);
        check("R3 irq pulse", irq_o, 1'b1);
        check("R6 no wake when awake", wake_o, 1'b0);
        cyc(1);
        check("R3 irq single cycle", irq_o, 1'b0);
        rd(1'b1, v); check("R3 counts on after reload", v, 8'hFE);
        rd(1'b0, v); check("R10 enable kept after overflow", v, 8'h90);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_slow();
        logic [7:0] v;
        wr(1'b1, 8'h00);
        wr(1'b0, 8'hB0);
        cyc(5);
        rd(1'b1, v); check("R4 slow source idle", v, 8'h00);
        for (int i = 0; i < 3; i++) begin
            slow_tick = 1'b1; @(negedge clk);
            slow_tick = 1'b0; @(negedge clk);
        end
        rd(1'b1, v); check("R4 slow source counts ticks", v, 8'h03);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_event();
        logic [7:0] v;
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h58);
        tmr_pin = 1'b1;
        cyc(2);
        rd(1'b1, v); check("R5 event latency not yet", v, 8'h00);
        cyc(1);
        rd(1'b1, v); check("R5 event counted at third edge", v, 8'h01);
        cyc(2); tmr_pin = 1'b0; cyc(4);
        for (int i = 0; i < 2; i++) begin
            tmr_pin = 1'b1; cyc(4); tmr_pin = 1'b0; cyc(4);
        end
        rd(1'b1, v); check("R5 rising edges", v, 8'h03);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
        sleep_i = 1'b1;
        wr(1'b0, 8'h57);
        for (int i = 0; i < 2; i++) begin
            tmr_pin = 1'b1; cyc(4); tmr_pin = 1'b0; cyc(4);
        end
        rd(1'b1, v); check("R5 R6 falling edges during sleep", v, 8'h02);
        wr(1'b0, 8'h00);
        sleep_i = 1'b0;
    endtask

    task automatic t_sleep();
        logic [7:0] v;
        logic seen_irq, seen_wake;
        wr(1'b1, 8'h20);
        sleep_i = 1'b1;
        wr(1'b0, 8'h90);
        cyc(5);
        rd(1'b1, v); check("R6 timer held in sleep", v, 8'h20);
        sleep_i = 1'b0;
        cyc(3);
        rd(1'b1, v); check("R6 timer resumes", v, 8'h23);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'hFF);
        sleep_i = 1'b1;
        wr(1'b0, 8'h58);
        seen_irq = 1'b0; seen_wake = 1'b0;
        tmr_pin = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (irq_o) seen_irq = 1'b1;
            if (wake_o) seen_wake = 1'b1;
        end
        check("R6 irq on sleep overflow", seen_irq, 1'b1);
        check("R6 wake on sleep overflow", seen_wake, 1'b1);
        rd(1'b1, v); check("R3 event wrap reload", v, 8'hFF);
        tmr_pin = 1'b0; cyc(4);
        sleep_i = 1'b0;
        wr(1'b0, 8'h00);
    endtask

    task automatic t_capture_low();
        logic [7:0] v;
        tmr_pin = 1'b1; cyc(4);
        wr(1'b1, 8'h33);
        wr(1'b0, 8'hD0);
        rd(1'b1, v); check("R7 arm clears counter", v, 8'h00);
        cyc(5);
        rd(1'b1, v); check("R7 armed waits for edge", v, 8'h00);
        rd(1'b0, v); check("R7 armed enable set", v, 8'hD0);
        tmr_pin = 1'b0; cyc(6);
        tmr_pin = 1'b1; cyc(5);
        rd(1'b1, v); check("R8 low pulse width", v, 8'h06);
        rd(1'b0, v); check("R9 enable auto-cleared", v, 8'hC0);
        tmr_pin = 1'b0; cyc(3); tmr_pin = 1'b1; cyc(5);
        rd(1'b1, v); check("R9 count held after stop", v, 8'h06);
    endtask

    task automatic t_capture_high();
        logic [7:0] v;
        tmr_pin = 1'b0; cyc(4);
        wr(1'b0, 8'hD8);
        cyc(3);
        tmr_pin = 1'b1; cyc(9);
        tmr_pin = 1'b0; cyc(5);
        rd(1'b1, v); check("R8 high pulse width", v, 8'h09);
        rd(1'b0, v); check("R9 enable auto-cleared high", v, 8'hC8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_timer();
        t_overflow();
        t_slow();
        t_event();
        t_sleep();
        t_capture_low();
        t_capture_high();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule